// File: doc/BRIEF.md
# Packed-Byte Video Arithmetic Unit

This block is a small SIMD arithmetic stage for pixel work. It splits each of two 32-bit operands into four unsigned byte lanes, or into two signed halfword lanes. It then applies one of four operations to every lane at once:

- a clipped add per byte;
- a clipped add per halfword;
- a rounded or truncated average per byte;
- a sum of absolute byte differences, which also feeds a bank of running totals.

The operands arrive already aligned from upstream logic. The result leaves as a registered 32-bit word.

The difference-sum operation is used for block matching. Each issue adds the absolute difference of every byte pair into that lane's own accumulator. Software-visible control clears the accumulators with a single strobe before a new block starts. Each accumulator sticks at its all-ones value instead of wrapping.

Top module: `pxl_simd_alu`

## Requirements
- R1: When `in_valid_i` is high at a rising edge, `out_valid_o` is high and `result_o` holds that operation's result after that edge. When `in_valid_i` is low, `out_valid_o` goes low and `result_o` keeps its value.
- R2: Opcode 0 adds the operands as four unsigned bytes. Byte lane i occupies bits 8i+7..8i. A lane sum above 255 is clipped to 255.
- R3: Opcode 1 adds the operands as two signed halfwords. Halfword j occupies bits 16j+15..16j. A lane sum is clipped to the range -32768..32767.
- R4: Opcode 2 gives (a+b+1)>>1 per byte lane when `trunc_i` is 0, and (a+b)>>1 when it is 1. `trunc_i` has no effect on any other opcode.
- R5: Opcode 3 puts |a-b| into each byte lane of `result_o`. It also adds that value into lane i's accumulator, which is found at `acc_o[ACC_W*i +: ACC_W]`.
- R6: An accumulator whose sum would exceed 2^ACC_W-1 stays at 2^ACC_W-1.
- R7: `acc_clr_i` high at an edge zeroes every accumulator after that edge. It wins over an opcode 3 issued in the same cycle.
- R8: Accumulators do not change when `in_valid_i` is low or when the opcode is not 3.
- R9: After reset, `result_o`, `out_valid_o` and every accumulator are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Issues an operation this cycle |
| op_i | input | 2 | 0 byte add, 1 halfword add, 2 byte average, 3 difference sum |
| trunc_i | input | 1 | Average truncates instead of rounding |
| acc_clr_i | input | 1 | Zeroes all accumulators |
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand |
| out_valid_o | output | 1 | Result register was loaded on the last edge |
| result_o | output | DATA_W | Registered lane-wise result |
| acc_o | output | LANES*ACC_W | Per-lane difference accumulators |

## Verification
The bench builds the block with `DATA_W` at its default of 32, which gives four byte lanes and two halfword lanes. It sets `ACC_W` to 10. With that narrower accumulator, five difference sums of 255 per lane carry every lane past 1023. This exercises the clip at the top of the range, and the behaviour just below it, in a few cycles. The same source elaborates with the 16-bit default, where the hold point is 0xFFFF.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    OP_BADD = 2'd0,
    OP_HADD = 2'd1,
    OP_BAVG = 2'd2,
    OP_SAA  = 2'd3
  } pxl_op_e;

  // Unsigned byte sum with the carry kept
  function automatic logic [BYTE_W:0] byte_sum(input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [BYTE_W-1:0] byte_clip(input logic [BYTE_W:0] s);
    return s[BYTE_W] ? {BYTE_W{1'b1}} : s[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] byte_avg(input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b,
                                                 input logic trunc);
    logic [BYTE_W:0] s;
    s = {1'b0, a} + {1'b0, b} + {{BYTE_W{1'b0}}, ~trunc};
    return s[BYTE_W:1];
  endfunction

  function automatic logic [BYTE_W-1:0] byte_absdiff(input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // Signed halfword sum with one guard bit
  function automatic logic [HALF_W:0] half_sum(input logic [HALF_W-1:0] a, input logic [HALF_W-1:0] b);
    return {a[HALF_W-1], a} + {b[HALF_W-1], b};
  endfunction

endpackage

// File: rtl/pxl_byte_lane.sv
module pxl_byte_lane
  import pxl_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              trunc_i,
  output logic [BYTE_W-1:0] add_o,
  output logic [BYTE_W-1:0] avg_o,
  output logic [BYTE_W-1:0] diff_o,
  output logic              clip_hit_o
);

  logic [BYTE_W:0] sum_w;

  assign sum_w      = byte_sum(a_i, b_i);
  assign clip_hit_o = sum_w[BYTE_W];
  assign add_o      = byte_clip(sum_w);
  assign avg_o      = byte_avg(a_i, b_i, trunc_i);
  assign diff_o     = byte_absdiff(a_i, b_i);

endmodule

// File: rtl/pxl_half_add.sv
module pxl_half_add
  import pxl_pkg::*;
(
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [HALF_W-1:0] sum_o,
  output logic              pos_sat_o,
  output logic              neg_sat_o
);

  logic [HALF_W:0] ext_w;

  assign ext_w     = half_sum(a_i, b_i);
  assign pos_sat_o = ~ext_w[HALF_W] &  ext_w[HALF_W-1];
  assign neg_sat_o =  ext_w[HALF_W] & ~ext_w[HALF_W-1];

  always_comb begin
    if (pos_sat_o)      sum_o = {1'b0, {(HALF_W-1){1'b1}}};
    else if (neg_sat_o) sum_o = {1'b1, {(HALF_W-1){1'b0}}};
    else                sum_o = ext_w[HALF_W-1:0];
  end

endmodule

// File: rtl/pxl_saa_acc.sv
module pxl_saa_acc
  import pxl_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_en_i,
  input  logic [BYTE_W-1:0] diff_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              sat_hit_o
);

  localparam int PAD_W = ACC_W + 1 - BYTE_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   nxt_w;

  assign nxt_w     = {1'b0, acc_q} + {{PAD_W{1'b0}}, diff_i};
  assign sat_hit_o = nxt_w[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (add_en_i) acc_q <= sat_hit_o ? {ACC_W{1'b1}} : nxt_w[ACC_W-1:0];
  end

  assign acc_o = acc_q;

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_o == '0)); // R7
  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && add_en_i) |=> (acc_o >= $past(acc_o))); // R6
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !add_en_i) |=> $stable(acc_o)); // R8

endmodule

// File: rtl/pxl_simd_alu.sv
module pxl_simd_alu
  import pxl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid_i,
  input  logic [1:0]                    op_i,
  input  logic                          trunc_i,
  input  logic                          acc_clr_i,
  input  logic [DATA_W-1:0]             opa_i,
  input  logic [DATA_W-1:0]             opb_i,
  output logic                          out_valid_o,
  output logic [DATA_W-1:0]             result_o,
  output logic [DATA_W/BYTE_W*ACC_W-1:0] acc_o
);

  localparam int LANES  = DATA_W / BYTE_W;
  localparam int HALVES = DATA_W / HALF_W;

  pxl_op_e op_w;
  assign op_w = pxl_op_e'(op_i);

  logic [DATA_W-1:0] badd_w, bavg_w, diff_w, hadd_w;
  logic [LANES-1:0]  byte_clip_w, acc_sat_w;
  logic [HALVES-1:0] hpos_w, hneg_w;
  logic              saa_fire_w;

  assign saa_fire_w = in_valid_i && (op_w == OP_SAA);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pxl_byte_lane u_lane (
      .a_i       (opa_i[BYTE_W*g +: BYTE_W]),
      .b_i       (opb_i[BYTE_W*g +: BYTE_W]),
      .trunc_i   (trunc_i),
      .add_o     (badd_w[BYTE_W*g +: BYTE_W]),
      .avg_o     (bavg_w[BYTE_W*g +: BYTE_W]),
      .diff_o    (diff_w[BYTE_W*g +: BYTE_W]),
      .clip_hit_o(byte_clip_w[g])
    );

    pxl_saa_acc #(.ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (acc_clr_i),
      .add_en_i (saa_fire_w),
      .diff_i   (diff_w[BYTE_W*g +: BYTE_W]),
      .acc_o    (acc_o[ACC_W*g +: ACC_W]),
      .sat_hit_o(acc_sat_w[g])
    );

    AST_BADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && op_i == 2'd0) |=>
        (result_o[BYTE_W*g +: BYTE_W] >= $past(opa_i[BYTE_W*g +: BYTE_W]))); // R2
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    pxl_half_add u_half (
      .a_i      (opa_i[HALF_W*h +: HALF_W]),
      .b_i      (opb_i[HALF_W*h +: HALF_W]),
      .sum_o    (hadd_w[HALF_W*h +: HALF_W]),
      .pos_sat_o(hpos_w[h]),
      .neg_sat_o(hneg_w[h])
    );
  end

  logic [DATA_W-1:0] result_d;

  always_comb begin
    unique case (op_w)
      OP_BADD: result_d = badd_w;
      OP_HADD: result_d = hadd_w;
      OP_BAVG: result_d = bavg_w;
      default: result_d = diff_w;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= result_d;
    end
  end

  AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!out_valid_o && $stable(result_o))); // R1

endmodule

// File: tb/pxl_simd_alu_tb_top.sv
`timescale 1ns/1ps
module pxl_simd_alu_tb_top;

  localparam int DATA_W = 32;
  localparam int ACC_W  = 10;
  localparam int LANES  = DATA_W / 8;
  localparam int AW     = LANES * ACC_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0]        op = 2'd0;
  logic              trunc = 1'b0;
  logic              acc_clr = 1'b0;
  logic [DATA_W-1:0] opa = '0;
  logic [DATA_W-1:0] opb = '0;
  logic              out_valid;
  logic [DATA_W-1:0] result;
  logic [AW-1:0]     acc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pxl_simd_alu #(.DATA_W(DATA_W), .ACC_W(ACC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op), .trunc_i(trunc),
    .acc_clr_i(acc_clr), .opa_i(opa), .opb_i(opb), .out_valid_o(out_valid),
    .result_o(result), .acc_o(acc)
  );

  // {op, trunc, a, b, expected}
  localparam logic [98:0] VEC [10] = '{
    {2'd0, 1'b0, 32'h1080FF01, 32'h208001FE, 32'h30FFFFFF},
    {2'd0, 1'b0, 32'h00000000, 32'h12345678, 32'h12345678},
    {2'd0, 1'b1, 32'h00000000, 32'h12345678, 32'h12345678},
    {2'd1, 1'b0, 32'h7FFF0001, 32'h00010002, 32'h7FFF0003},
    {2'd1, 1'b0, 32'h8000FFFF, 32'hFFFF0001, 32'h80000000},
    {2'd1, 1'b1, 32'h1234F000, 32'h0100F000, 32'h1334E000},
    {2'd2, 1'b0, 32'h01FF0003, 32'h02FF0004, 32'h02FF0004},
    {2'd2, 1'b1, 32'h01FF0003, 32'h02FF0004, 32'h01FF0003},
    {2'd2, 1'b0, 32'h00FE8001, 32'hFF018000, 32'h80808001},
    {2'd2, 1'b1, 32'h00FE8001, 32'hFF018000, 32'h7F7F8000}
  };

  function automatic logic [AW-1:0] pack4(input int l3, input int l2, input int l1, input int l0);
    return {ACC_W'(l3), ACC_W'(l2), ACC_W'(l1), ACC_W'(l0)};
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] o, input logic t, input logic c,
                      input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    @(negedge clk);
    in_valid = v; op = o; trunc = t; acc_clr = c; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0; acc_clr = 1'b0;
  endtask

  initial begin
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    check("R9", "reset result", 64'(result), 64'h0);
    check("R9", "reset out_valid", 64'(out_valid), 64'h0);
    check("R9", "reset acc", 64'(acc), 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      string tag;
      tag = (VEC[i][98:97] == 2'd0) ? "R2" : (VEC[i][98:97] == 2'd1) ? "R3" : "R4";
      step(1'b1, VEC[i][98:97], VEC[i][96], 1'b0, VEC[i][95:64], VEC[i][63:32]);
      check(tag, "table result", 64'(result), 64'(VEC[i][31:0]));
      check("R1", "out_valid after issue", 64'(out_valid), 64'h1);
    end

    // R1: idle cycle holds the result and drops valid
    held = result;
    @(negedge clk);
    check("R1", "idle out_valid", 64'(out_valid), 64'h0);
    check("R1", "idle result hold", 64'(result), 64'(held));
    check("R8", "acc untouched by non-SAA ops", 64'(acc), 64'h0);

    // R5: difference sum and accumulation
    step(1'b1, 2'd3, 1'b0, 1'b0, 32'h1000FF05, 32'h01FF000A);
    check("R5", "abs diff result", 64'(result), 64'h0FFFFF05);
    check("R5", "acc after one", 64'(acc), 64'(pack4(15, 255, 255, 5)));
    step(1'b1, 2'd3, 1'b1, 1'b0, 32'h01FF000A, 32'h1000FF05);
    check("R5", "swapped abs diff", 64'(result), 64'h0FFFFF05);
    check("R5", "acc after two", 64'(acc), 64'(pack4(30, 510, 510, 10)));

    // R8: SAA opcode without valid, and valid non-SAA op
    step(1'b0, 2'd3, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h0);
    check("R8", "acc with valid low", 64'(acc), 64'(pack4(30, 510, 510, 10)));
    step(1'b1, 2'd0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h0);
    check("R8", "acc with byte add", 64'(acc), 64'(pack4(30, 510, 510, 10)));

    // R7: clear wins over SAA in the same cycle
    step(1'b1, 2'd3, 1'b0, 1'b1, 32'h1000FF05, 32'h01FF000A);
    check("R7", "clear over SAA", 64'(acc), 64'h0);
    check("R5", "result with clear", 64'(result), 64'h0FFFFF05);

    // R6: saturation at 2^ACC_W-1 = 1023
    for (int k = 0; k < 4; k++) step(1'b1, 2'd3, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h0);
    check("R6", "just below top", 64'(acc), 64'(pack4(1020, 1020, 1020, 1020)));
    step(1'b1, 2'd3, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h0);
    check("R6", "clipped at top", 64'(acc), 64'(pack4(1023, 1023, 1023, 1023)));
    step(1'b1, 2'd3, 1'b0, 1'b0, 32'h00000000, 32'h01010101);
    check("R6", "stays at top", 64'(acc), 64'(pack4(1023, 1023, 1023, 1023)));

    // R7: clear alone
    step(1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0);
    check("R7", "clear alone", 64'(acc), 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule